// File: doc/BRIEF.md
# Interrupt status and mask controller

This block holds the interrupt state of one DMA channel. Eight event sources come in from the channel as one-cycle pulses. Each pulse latches a sticky status bit. Software clears a status bit by writing a 1 to it.

A mask decides which latched sources raise the single level interrupt line. Software never writes the mask directly. It writes 1s to an unmask port, which clears mask bits, or to a mask-set port, which sets them. The mask itself can only be read.

A 3-bit counter tracks completed transfers. Each done event increments it. Each software acknowledge of a pending done status decrements it. The counter is read back together with the status bits.

Top module: `isc_top`

## Requirements
- R1: After reset, all status bits and the done counter are 0, all 8 mask bits are 1 (every source masked), and `irq_o` is 0.
- R2: A pulse on `evt_i[i]` sets status bit i at the next clock edge. The source bits are: 7 FIFO overflow, 6 invalid register access, 5 threshold hit, 4 memory timeout, 3 stream timeout, 2 bus write-response error, 1 done, 0 memory done.
- R3: A write to address 0 (status) clears each status bit whose `wdata_i` bit is 1. Status bits whose `wdata_i` bit is 0 keep their value.
- R4: If an event pulse and a status clear hit the same bit in the same cycle, the bit ends up set.
- R5: A write to address 1 (unmask) clears each mask bit whose `wdata_i` bit is 1. Other mask bits keep their value.
- R6: A write to address 2 (mask-set) sets each mask bit whose `wdata_i` bit is 1. Other mask bits keep their value.
- R7: Reads return the following: address 0 gives the status in `rdata_o[7:0]` and the done counter in `rdata_o[15:13]`; address 3 gives the mask in `rdata_o[7:0]`; addresses 1 and 2 give 0. A write to address 3 changes nothing.
- R8: `irq_o` is a register. One clock edge after status or mask changes, it equals the OR of (status AND NOT mask).
- R9: Each pulse on the done source (`evt_i[1]`) increments the done counter. The counter wraps modulo 8.
- R10: A status write that clears the done bit while that bit is set decrements the counter. Clearing an already clear done bit leaves the counter unchanged. An increment and a decrement in the same cycle cancel out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 8 | Hardware event pulses, one bit per source |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 status, 1 unmask, 2 mask-set, 3 mask |
| wdata_i | input | 8 | Write data, one bit per source |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
Status, mask and counter changes take effect at the clock edge that samples the event or write. The bench therefore updates its model at that same edge and reads the registers back in the low phase that follows. The read path is combinational, so it adds no delay. `irq_o` passes through one more register, so it is due one edge after the status or mask change that causes it. The model computes the expected interrupt from the state held before each edge, and it is compared one cycle behind the state checks.

// File: rtl/isc_pkg.sv
package isc_pkg;
   localparam int ADDR_W = 2;

   // Register select values; the numbering is the software address map.
   typedef enum logic [ADDR_W-1:0] {
      RG_STAT    = 2'd0,
      RG_UNMASK  = 2'd1,
      RG_MASKSET = 2'd2,
      RG_MASK    = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/isc_status.sv
module isc_status #(
   parameter int NUM_SRC  = 8,
   parameter int CNT_W    = 3,
   parameter int DONE_BIT = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               clr_req_i,
   input  logic [NUM_SRC-1:0] clr_bits_i,
   output logic [NUM_SRC-1:0] stat_o,
   output logic [CNT_W-1:0]   cnt_o
);
   logic [NUM_SRC-1:0] stat_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               ack, inc;

   initial begin : p_param_chk
      assert (DONE_BIT < NUM_SRC) else $error("DONE_BIT out of range");
      assert (CNT_W > 0) else $error("CNT_W must be positive");
   end

   // One sticky flop per source; a hardware set wins over a software clear.
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          stat_q[i] <= 1'b0;
         else if (evt_i[i])                   stat_q[i] <= 1'b1;
         else if (clr_req_i && clr_bits_i[i]) stat_q[i] <= 1'b0;
      end
   end

   assign ack = clr_req_i & clr_bits_i[DONE_BIT] & stat_q[DONE_BIT];
   assign inc = evt_i[DONE_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else begin
         case ({inc, ack})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign stat_o = stat_q;
   assign cnt_o  = cnt_q;

   // R2, R4: every pulsed source reads as set after the edge
   assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

   // R3: cleared bits without a competing event read as zero
   assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req_i |=> ((stat_q & $past(clr_bits_i & ~evt_i)) == '0));

   assert_cnt_inc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ack) |=> (cnt_q == $past(cnt_q) + 1'b1));

   assert_cnt_dec_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !inc) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/isc_mask.sv
module isc_mask #(
   parameter int NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               unmask_wr_i,
   input  logic               set_wr_i,
   input  logic [NUM_SRC-1:0] bits_i,
   output logic [NUM_SRC-1:0] mask_o
);
   logic [NUM_SRC-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           mask_q <= '1;
      else if (unmask_wr_i) mask_q <= mask_q & ~bits_i;
      else if (set_wr_i)    mask_q <= mask_q | bits_i;
   end

   assign mask_o = mask_q;

   assert_unmask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      unmask_wr_i |=> ((mask_q & $past(bits_i)) == '0));

   assert_maskset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (set_wr_i && !unmask_wr_i) |=> ((mask_q & $past(bits_i)) == $past(bits_i)));

   assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!unmask_wr_i && !set_wr_i) |=> $stable(mask_q));
endmodule

// File: rtl/isc_irq.sv
module isc_irq #(
   parameter int NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] stat_i,
   input  logic [NUM_SRC-1:0] mask_i,
   output logic               irq_o
);
   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(stat_i & ~mask_i);
   end

   assign irq_o = irq_q;

   assert_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_q == (|($past(stat_i) & ~$past(mask_i)))));
endmodule

// File: rtl/isc_top.sv
module isc_top
   import isc_pkg::*;
#(
   parameter int NUM_SRC  = 8,
   parameter int CNT_W    = 3,
   parameter int DONE_BIT = 1,
   parameter int CNT_LSB  = 13,
   parameter int DATA_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               wr_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [NUM_SRC-1:0] wdata_i,
   output logic [DATA_W-1:0]  rdata_o,
   output logic               irq_o
);
   localparam int CNT_MSB = CNT_LSB + CNT_W - 1;

   initial begin : p_param_chk
      assert (CNT_MSB < DATA_W) else $error("counter field exceeds DATA_W");
      assert (NUM_SRC <= CNT_LSB) else $error("sources overlap counter field");
   end

   reg_sel_e           sel;
   logic [NUM_SRC-1:0] stat, mask;
   logic [CNT_W-1:0]   cnt;
   logic               wr_stat, wr_unmask, wr_set;

   assign sel       = reg_sel_e'(addr_i);
   assign wr_stat   = wr_i && (sel == RG_STAT);
   assign wr_unmask = wr_i && (sel == RG_UNMASK);
   assign wr_set    = wr_i && (sel == RG_MASKSET);

   isc_status #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W), .DONE_BIT(DONE_BIT)) u_status (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
      .clr_req_i(wr_stat), .clr_bits_i(wdata_i),
      .stat_o(stat), .cnt_o(cnt));

   isc_mask #(.NUM_SRC(NUM_SRC)) u_mask (
      .clk(clk), .rst_n(rst_n), .unmask_wr_i(wr_unmask), .set_wr_i(wr_set),
      .bits_i(wdata_i), .mask_o(mask));

   isc_irq #(.NUM_SRC(NUM_SRC)) u_irq (
      .clk(clk), .rst_n(rst_n), .stat_i(stat), .mask_i(mask), .irq_o(irq_o));

   always_comb begin
      rdata_o = '0;
      case (sel)
         RG_STAT: begin
            rdata_o[NUM_SRC-1:0]       = stat;
            rdata_o[CNT_MSB:CNT_LSB]   = cnt;
         end
         RG_MASK: rdata_o[NUM_SRC-1:0] = mask;
         default: rdata_o = '0;
      endcase
   end
endmodule

// File: tb/isc_top_test.sv
module isc_top_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  evt = '0;
   logic        wr = 1'b0;
   logic [1:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [15:0] rdata;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;

   logic [7:0] m_stat = '0;
   logic [7:0] m_mask = 8'hFF;
   logic [2:0] m_cnt  = '0;
   logic       m_irq  = 1'b0;

   isc_top uut (.clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_i(wr), .addr_i(addr),
                .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] f_stat(logic [7:0] s, logic [7:0] e, logic w,
                                         logic [1:0] a, logic [7:0] d);
      return (s & ~((w && a == 2'd0) ? d : 8'h00)) | e;
   endfunction

   function automatic logic [7:0] f_mask(logic [7:0] m, logic w, logic [1:0] a,
                                         logic [7:0] d);
      if (w && a == 2'd1) return m & ~d;
      if (w && a == 2'd2) return m | d;
      return m;
   endfunction

   function automatic logic [2:0] f_cnt(logic [2:0] c, logic [7:0] s, logic [7:0] e,
                                        logic w, logic [1:0] a, logic [7:0] d);
      logic [2:0] r;
      r = c;
      if (e[1]) r = r + 3'd1;
      if (w && a == 2'd0 && d[1] && s[1]) r = r - 3'd1;
      return r;
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive at negedge, model commits at the edge, return at the next negedge.
   task automatic tick(input logic [7:0] e, input logic w, input logic [1:0] a,
                       input logic [7:0] d);
      logic [7:0] ns, nm;
      logic [2:0] nc;
      logic       ni;
      evt = e; wr = w; addr = a; wdata = d;
      ns = f_stat(m_stat, e, w, a, d);
      nm = f_mask(m_mask, w, a, d);
      nc = f_cnt(m_cnt, m_stat, e, w, a, d);
      ni = |(m_stat & ~m_mask);
      @(posedge clk);
      m_stat = ns; m_mask = nm; m_cnt = nc; m_irq = ni;
      #1;
      evt = '0; wr = 1'b0;
      @(negedge clk);
   endtask

   task automatic chk_all(input string req);
      addr = 2'd0; #1; check({req, " status"}, rdata, {m_cnt, 5'b0, m_stat});
      addr = 2'd3; #1; check({req, " mask"}, rdata, {8'h00, m_mask});
      addr = 2'd1; #1; check({req, " unmask reads 0"}, rdata, 16'h0);
      addr = 2'd2; #1; check({req, " maskset reads 0"}, rdata, 16'h0);
      check({req, " irq"}, {15'b0, irq}, {15'b0, m_irq});
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_all("R1 reset");

      // R2: each source alone; masked so irq stays low (R8)
      for (int i = 0; i < 8; i++) begin
         tick(8'h01 << i, 1'b0, 2'd0, 8'h00);
         chk_all("R2 event sets");
      end
      // R3: write zeros changes nothing, then clear bit 3
      tick(8'h00, 1'b1, 2'd0, 8'h00); chk_all("R3 zero write");
      tick(8'h00, 1'b1, 2'd0, 8'h08); chk_all("R3 clear bit");
      // R5 + R8: unmask bit 7, irq follows one edge later
      tick(8'h00, 1'b1, 2'd1, 8'h80);
      check("R8 irq not yet", {15'b0, irq}, 16'h0);
      chk_all("R5 unmask");
      tick(8'h00, 1'b0, 2'd0, 8'h00);
      check("R8 irq raised", {15'b0, irq}, 16'h1);
      // R6: mask it again
      tick(8'h00, 1'b1, 2'd2, 8'h80); chk_all("R6 maskset");
      tick(8'h00, 1'b0, 2'd0, 8'h00);
      check("R8 irq dropped", {15'b0, irq}, 16'h0);
      // R7: write to mask address ignored
      tick(8'h00, 1'b1, 2'd3, 8'hFF); chk_all("R7 ro mask");
      tick(8'h00, 1'b1, 2'd1, 8'h0F); tick(8'h00, 1'b1, 2'd3, 8'hFF);
      chk_all("R7 ro mask after unmask");
      // R4: set and clear same bit same cycle
      tick(8'h20, 1'b1, 2'd0, 8'h20); chk_all("R4 set wins");
      // R10: ack pending done (count 1 -> 0), then ack while clear
      tick(8'h00, 1'b1, 2'd0, 8'h02); chk_all("R10 ack decrements");
      tick(8'h00, 1'b1, 2'd0, 8'h02); chk_all("R10 ack of clear bit");
      // R9: nine done events -> wraps to 1
      for (int i = 0; i < 9; i++) tick(8'h02, 1'b0, 2'd0, 8'h00);
      chk_all("R9 wrap");
      check("R9 count", {13'b0, rdata[15:13]}, 16'h0);
      addr = 2'd0; #1; check("R9 count value", {13'b0, rdata[15:13]}, 16'h1);
      // R10: ack and new done event in the same cycle cancel
      tick(8'h02, 1'b1, 2'd0, 8'h02); chk_all("R10 net zero");

      // Random mix
      for (int k = 0; k < 3000; k++) begin
         logic [7:0] e;
         logic [1:0] a;
         e = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
         a = 2'($urandom);
         tick(e, 1'($urandom % 2), a, 8'($urandom));
         if ((k % 3) == 0) chk_all("R2 R3 R5 R6 R8 R9 R10 random");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule